// File: doc/BRIEF.md
# Response-Driven Self-Test Harness

This block wraps a small combinational circuit under test with three equal-width test registers that switch between three roles. The stimulus register is an autonomous shift register with linear feedback. It drives the low half of the circuit inputs. The middle register drives the high half of the circuit inputs. It is also a multiple-input signature register that absorbs the low half of the circuit outputs. The back register compacts the high half of the outputs the same way. Because the middle register both feeds and observes the circuit, the stimulus depends on the circuit's own response. Some input patterns may therefore occur more than once, and others may never occur.

A test starts by loading a seed through a serial chain while the harness is in scan mode. The harness then runs in test mode for a programmed number of clocks. It raises a done flag when the run ends, and a pass flag when the two signature registers match the expected signature. The final signature can also be shifted out serially. A seed of zero in the stimulus register would lock the feedback register. Such a seed is rejected and a sticky error flag is raised. In functional mode the registers hold their contents and the circuit takes its inputs from the functional port.

Top module: `rtd_bist_harness`

## Requirements
- R1: After a synchronous active-low reset, all three test registers are zero, and `done_o`, `pass_o` and `seed_err_o` are low.
- R2: With `mode_i`=2'b01 (scan), each clock shifts the chain stimulus, then middle, then back register. `scan_i` enters stimulus bit 0, and each register's bit W-1 feeds bit 0 of the next register. `scan_o` always shows bit W-1 of the back register.
- R3: If the stimulus register is zero while `mode_i`=2'b10 (test), no register changes and `done_o` stays low. `seed_err_o` rises one clock later and stays high until the next scan clock.
- R4: On each test step, the stimulus register s becomes {s[W-2:0], ^(s & TAPS)}, with TAPS=8'hB8 by default.
- R5: On each test step, a signature register r with absorbed data d becomes {r[W-2:0], ^(r & TAPS)} ^ d. The middle register absorbs circuit output bits [W-1:0], and the back register absorbs bits [2W-1:W]. In test mode the circuit inputs are a = stimulus register and b = middle register.
- R6: In test mode the harness makes exactly `limit_i` steps. `done_o` is high once the step count equals `limit_i`, including immediately when `limit_i` is 0. After that the registers hold.
- R7: `pass_o` is high only while `done_o` is high and {middle, back} equals `expect_i`.
- R8: With `mode_i`=2'b00 (functional), a = `func_i[W-1:0]` and b = `func_i[2W-1:W]`, and the registers hold their contents. `func_o` = {a + b, a ^ (b & rotl(a,1))} in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 00 functional, 01 scan, 10 test, 11 treated as functional |
| scan_i | input | 1 | Serial chain input |
| scan_o | output | 1 | Serial chain output |
| limit_i | input | 16 | Number of test steps in a run |
| expect_i | input | 16 | Expected signature {middle, back} |
| func_i | input | 16 | Functional circuit inputs {b, a} |
| func_o | output | 16 | Circuit outputs {high, low} |
| done_o | output | 1 | Run has completed its steps |
| pass_o | output | 1 | Run completed and signature matches |
| seed_err_o | output | 1 | Zero stimulus seed was rejected |

## Verification
Two runs use different nonzero seeds and different lengths. The final signatures are compared both serially and through `pass_o`, so that a wrong polynomial, a swapped absorb path or an off-by-one step count shows up as a signature mismatch. The same run with a wrong expected value separates the comparison from the done flag. An all-zero stimulus seed and a zero step limit both check that the registers stay untouched, which is read back through the chain. A scan round trip and a functional-mode pattern confirm the chain order and the functional input selection.

// File: rtl/rtdb_pkg.sv
// Package: shared mode encoding and the register step function for the
// self-test harness. Assumes registers of at least two bits.
package rtdb_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC = 2'b00,
        MODE_SCAN = 2'b01,
        MODE_TEST = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    // Left shift with parity feedback of the tapped bits (width fixed at 16 max).
    function automatic logic [15:0] shift_fb(input logic [15:0] r,
                                             input logic [15:0] taps,
                                             input int unsigned w);
        logic [15:0] res;
        logic        fb;
        fb  = ^(r & taps);
        res = {r[14:0], fb};
        res = res & ((16'h1 << w) - 16'h1);
        return res;
    endfunction

endpackage

// File: rtl/rtdb_treg.sv
// Test register: one link of the scan chain. In scan it shifts serial data
// in at bit 0. On a step it advances with parity feedback and, in the
// signature variant, XORs in parallel data. Otherwise it holds.
// Assumes scan_en and step_en are never high together.
module rtdb_treg #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] TAPS   = 8'hB8,
    parameter bit          IS_MISR = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic         step_en,
    input  logic         scan_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o,
    output logic         scan_o
);
    import rtdb_pkg::*;

    localparam logic [W-1:0] INJ_MASK = IS_MISR ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] q;
    logic [W-1:0] adv;
    logic [15:0]  adv_wide;

    // Feedback advance computed through the shared step function.
    always_comb begin
        adv_wide = shift_fb(16'(q), 16'(TAPS), W);
        adv      = adv_wide[W-1:0] ^ (par_i & INJ_MASK);
    end

    // Register update: reset, scan shift, test step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (scan_en) q <= {q[W-2:0], scan_i};
        else if (step_en) q <= adv;
    end

    assign q_o    = q;
    assign scan_o = q[W-1];

    // R2: serial input lands in bit 0 after a scan clock.
    a_r2_scan_entry: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> q[0] == $past(scan_i));

    generate
        if (!IS_MISR) begin : g_lfsr_chk
            // R4: a nonzero stimulus register never steps into zero.
            a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
                (step_en && q != '0) |=> q != '0);
        end else begin : g_misr_chk
            // R5: with nothing absorbed the register shifts left.
            a_r5_misr_shift: assert property (@(posedge clk) disable iff (!rst_n)
                step_en |=> q[W-1:1] == $past(q[W-2:0] ^ par_i[W-1:1]));
        end
    endgenerate
endmodule

// File: rtl/rtdb_cut.sv
// Example circuit under test: purely combinational. It returns the sum of
// its two operands in the high half and a masked XOR in the low half.
// Assumes W >= 2.
module rtdb_cut #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] y_o
);
    logic [W-1:0] rot_a;

    // Low half: a XOR (b AND a rotated left); high half: a + b.
    always_comb begin
        rot_a = {a_i[W-2:0], a_i[W-1]};
        y_o   = {a_i + b_i, a_i ^ (b_i & rot_a)};
    end
endmodule

// File: rtl/rtdb_ctrl.sv
// Mode controller and cycle counter. It decodes the mode, counts test
// steps up to the limit, gates stepping on a nonzero seed and keeps the
// sticky seed error. Assumes limit_i is stable during a run.
module rtdb_ctrl #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] limit_i,
    input  logic          seed_zero_i,
    output logic          scan_en_o,
    output logic          step_en_o,
    output logic          test_sel_o,
    output logic          done_o,
    output logic          seed_err_o
);
    import rtdb_pkg::*;

    mode_e         mode;
    logic [CW-1:0] cnt;
    logic          seed_err;
    logic          in_test;

    // Mode decode and step gating.
    always_comb begin
        mode       = mode_e'(mode_i);
        in_test    = (mode == MODE_TEST);
        scan_en_o  = (mode == MODE_SCAN);
        step_en_o  = in_test && (cnt != limit_i) && !seed_zero_i;
        test_sel_o = in_test;
        done_o     = in_test && (cnt == limit_i) && !seed_zero_i;
    end

    // Step counter: cleared outside test mode, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!in_test)  cnt <= '0;
        else if (step_en_o) cnt <= cnt + 1'b1;
    end

    // Sticky seed error: set by a zero seed in test mode, cleared by scan.
    always_ff @(posedge clk) begin
        if (!rst_n)                        seed_err <= 1'b0;
        else if (scan_en_o)                seed_err <= 1'b0;
        else if (in_test && seed_zero_i)   seed_err <= 1'b1;
    end

    assign seed_err_o = seed_err;

    // R6: the count never passes the limit during a run.
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && $stable(limit_i)) |-> cnt <= limit_i);
    // R3: a zero seed in test mode raises the error flag next cycle.
    a_r3_seed_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && seed_zero_i) |=> seed_err);
endmodule

// File: rtl/rtd_bist_harness.sv
// Top of the self-test harness. It chains three test registers
// (stimulus, middle signature, back signature) around the example circuit,
// selects the circuit inputs by mode and forms done and pass.
// Assumes expect_i and limit_i are held steady during a run.
module rtd_bist_harness #(
    parameter int unsigned  W    = 8,
    parameter int unsigned  CW   = 16,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic            scan_i,
    output logic            scan_o,
    input  logic [CW-1:0]   limit_i,
    input  logic [2*W-1:0]  expect_i,
    input  logic [2*W-1:0]  func_i,
    output logic [2*W-1:0]  func_o,
    output logic            done_o,
    output logic            pass_o,
    output logic            seed_err_o
);
    localparam int unsigned NREG = 3;

    logic [W-1:0]   q   [NREG];
    logic           so  [NREG];
    logic           si  [NREG];
    logic [W-1:0]   par [NREG];
    logic [W-1:0]   cut_a, cut_b;
    logic [2*W-1:0] cut_y;
    logic           scan_en, step_en, test_sel, done;

    rtdb_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .limit_i    (limit_i),
        .seed_zero_i(q[0] == '0),
        .scan_en_o  (scan_en),
        .step_en_o  (step_en),
        .test_sel_o (test_sel),
        .done_o     (done),
        .seed_err_o (seed_err_o)
    );

    // Chain links and absorbed data for each register position.
    always_comb begin
        si[0]  = scan_i;
        si[1]  = so[0];
        si[2]  = so[1];
        par[0] = '0;
        par[1] = cut_y[W-1:0];
        par[2] = cut_y[2*W-1:W];
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            rtdb_treg #(.W(W), .TAPS(TAPS), .IS_MISR(g != 0)) u_treg (
                .clk    (clk),
                .rst_n  (rst_n),
                .scan_en(scan_en),
                .step_en(step_en),
                .scan_i (si[g]),
                .par_i  (par[g]),
                .q_o    (q[g]),
                .scan_o (so[g])
            );
        end
    endgenerate

    // Circuit input selection: test registers in test mode, else functional port.
    always_comb begin
        cut_a = test_sel ? q[0] : func_i[W-1:0];
        cut_b = test_sel ? q[1] : func_i[2*W-1:W];
    end

    rtdb_cut #(.W(W)) u_cut (
        .a_i(cut_a),
        .b_i(cut_b),
        .y_o(cut_y)
    );

    assign func_o = cut_y;
    assign scan_o = so[2];
    assign done_o = done;
    assign pass_o = done && ({q[1], q[2]} == expect_i);

    // R8: functional mode leaves every register untouched.
    a_r8_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> ($stable(q[0]) && $stable(q[1]) && $stable(q[2])));
    // R6: once done in test mode, the registers freeze.
    a_r6_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_i == 2'b10) |=> ($stable(q[1]) && $stable(q[2])));
    // R3: a zero seed blocks stepping of the signature registers.
    a_r3_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && q[0] == '0) |=> ($stable(q[1]) && $stable(q[2])));
    // R7: pass never appears without done.
    a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);
endmodule

// File: tb/tb_rtd_bist_harness.sv
module tb_rtd_bist_harness;
    localparam int W  = 8;
    localparam int CW = 16;
    localparam logic [W-1:0] TAPS = 8'hB8;
    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      mode_i;
    logic            scan_i;
    logic            scan_o;
    logic [CW-1:0]   limit_i;
    logic [2*W-1:0]  expect_i;
    logic [2*W-1:0]  func_i;
    logic [2*W-1:0]  func_o;
    logic            done_o, pass_o, seed_err_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtd_bist_harness #(.W(W), .CW(CW), .TAPS(TAPS)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .scan_i(scan_i),
        .scan_o(scan_o), .limit_i(limit_i), .expect_i(expect_i),
        .func_i(func_i), .func_o(func_o), .done_o(done_o),
        .pass_o(pass_o), .seed_err_o(seed_err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fb_step(input logic [W-1:0] r);
        return {r[W-2:0], ^(r & TAPS)};
    endfunction

    function automatic logic [2*W-1:0] cut_model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] rot;
        rot = {a[W-2:0], a[W-1]};
        return {a + b, a ^ (b & rot)};
    endfunction

    task automatic scan_load(input logic [W-1:0] s1, input logic [W-1:0] s2, input logic [W-1:0] s3);
        logic [3*W-1:0] bits;
        bits = {s3, s2, s1};
        mode_i = 2'b01;
        for (int i = 3*W-1; i >= 0; i--) begin
            scan_i = bits[i];
            @(negedge clk);
        end
        mode_i = 2'b00;
        scan_i = 1'b0;
    endtask

    task automatic scan_unload(output logic [3*W-1:0] got);
        mode_i = 2'b01;
        scan_i = 1'b0;
        #1;
        for (int i = 3*W-1; i >= 0; i--) begin
            got[i] = scan_o;
            @(negedge clk);
            #1;
        end
        mode_i = 2'b00;
    endtask

    task automatic t_reset;
        logic [3*W-1:0] got;
        mode_i = 2'b00; scan_i = 0; limit_i = 0; expect_i = 0; func_i = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 done", 64'(done_o), 0);
        chk("R1 pass", 64'(pass_o), 0);
        chk("R1 seed_err", 64'(seed_err_o), 0);
        scan_unload(got);
        chk("R1 registers zero", 64'(got), 0);
    endtask

    task automatic t_scan_round;
        logic [3*W-1:0] got;
        scan_load(8'hA5, 8'h3C, 8'hE1);
        scan_unload(got);
        chk("R2 chain round trip", 64'(got), 64'({8'hE1, 8'h3C, 8'hA5}));
    endtask

    task automatic t_func;
        logic [3*W-1:0] got;
        scan_load(8'h11, 8'h22, 8'h33);
        func_i = {8'h9C, 8'h47};
        mode_i = 2'b00;
        #1;
        chk("R8 func output", 64'(func_o), 64'(cut_model(8'h47, 8'h9C)));
        func_i = {8'hFF, 8'h80};
        repeat (4) @(negedge clk);
        #1;
        chk("R8 func output wrap", 64'(func_o), 64'(cut_model(8'h80, 8'hFF)));
        mode_i = 2'b11;
        @(negedge clk);
        scan_unload(got);
        chk("R8 registers hold", 64'(got), 64'({8'h33, 8'h22, 8'h11}));
    endtask

    task automatic t_zero_seed;
        logic [3*W-1:0] got;
        scan_load(8'h00, 8'h5A, 8'hC3);
        limit_i = 16'd5;
        mode_i  = 2'b10;
        #1;
        chk("R3 flag not yet", 64'(seed_err_o), 0);
        @(negedge clk); #1;
        chk("R3 flag raised", 64'(seed_err_o), 1);
        repeat (6) @(negedge clk);
        #1;
        chk("R3 no done", 64'(done_o), 0);
        chk("R3 flag sticky", 64'(seed_err_o), 1);
        mode_i = 2'b00;
        @(negedge clk);
        scan_unload(got);
        chk("R3 registers untouched", 64'(got), 64'({8'hC3, 8'h5A, 8'h00}));
        chk("R3 flag cleared by scan", 64'(seed_err_o), 0);
    endtask

    task automatic t_run(input logic [W-1:0] s1, input logic [W-1:0] s2,
                         input logic [W-1:0] s3, input int n, input bit good);
        logic [W-1:0] m1, m2, m3;
        logic [2*W-1:0] y;
        logic [3*W-1:0] got;
        m1 = s1; m2 = s2; m3 = s3;
        for (int k = 0; k < n; k++) begin
            y  = cut_model(m1, m2);
            m1 = fb_step(m1);
            m2 = fb_step(m2) ^ y[W-1:0];
            m3 = fb_step(m3) ^ y[2*W-1:W];
        end
        scan_load(s1, s2, s3);
        limit_i  = CW'(n);
        expect_i = good ? {m2, m3} : ({m2, m3} ^ 16'h0100);
        mode_i   = 2'b10;
        #1;
        if (n == 0) begin
            chk("R6 zero limit done", 64'(done_o), 1);
        end else begin
            chk("R6 not done at start", 64'(done_o), 0);
            repeat (n - 1) @(negedge clk);
            #1;
            chk("R6 not done one early", 64'(done_o), 0);
            @(negedge clk); #1;
            chk("R6 done at limit", 64'(done_o), 1);
        end
        chk(good ? "R7 pass on match" : "R7 no pass on mismatch", 64'(pass_o), 64'(good));
        repeat (3) @(negedge clk);
        #1;
        chk("R6 done held", 64'(done_o), 1);
        mode_i = 2'b00;
        @(negedge clk); #1;
        chk("R7 pass drops with done", 64'(pass_o), 0);
        scan_unload(got);
        chk("R4 stimulus register", 64'(got[W-1:0]), 64'(m1));
        chk("R5 middle signature", 64'(got[2*W-1:W]), 64'(m2));
        chk("R5 back signature", 64'(got[3*W-1:2*W]), 64'(m3));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_scan_round();
        t_func();
        t_zero_seed();
        t_run(8'h01, 8'h00, 8'h00, 20, 1'b1);
        t_run(8'hB7, 8'h4E, 8'h92, 37, 1'b1);
        t_run(8'hB7, 8'h4E, 8'h92, 37, 1'b0);
        t_run(8'h6D, 8'h19, 8'hF0, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule